// File: doc/BRIEF.md
# Audio Sample Streaming DMA

This block plays 8-bit audio samples held in cartridge ROM by copying them, one at a time and at a programmable rate, into a DAC output register. The host CPU keeps running while this happens: the engine never stalls the processor or takes its bus. It fetches a sample only in a cycle where the CPU does not use the ROM. When a fetch falls due while the CPU holds the ROM, the fetch waits for the next free cycle.

The host writes six I/O registers to set up a transfer: the rate divider, the low and high bytes of the start address, the low and high bytes of the sample count, and finally the go register. The sample period is the divider value times one microsecond. A microsecond is a fixed number of clock cycles, set by a parameter. The divider may be rewritten during playback, and the new value governs the sample period that follows the current one. When the last sample has been written, the engine drops busy, raises done and holds the final sample on the DAC output.

Top module: `pcm_stream_dma`

## Requirements
- R1: After reset, busy, done, rom_req and dac_wr are 0 and dac_data is 0x00.
- R2: A write strobe with io_addr selects a register: 0 is the rate divider, 1 and 2 are the start address bits [7:0] and [15:8], 3 and 4 are the sample count bits [7:0] and [15:8], and 5 (any data) starts playback from the stored address and count.
- R3: Each fetched ROM byte appears unchanged on dac_data together with a one-cycle dac_wr pulse. The address rises by one per sample and wraps from 0xFFFF to 0x0000. dac_data changes only with dac_wr.
- R4: With divider D (0 meaning 256) and TICK_DIV clock cycles per microsecond, consecutive samples are D*TICK_DIV cycles apart when the CPU leaves the ROM free. The first dac_wr is seen D*TICK_DIV+2 clock edges after the edge that accepts the go write.
- R5: A divider write during playback leaves the current sample period unchanged and sets the length of every following period.
- R6: rom_req is never high in a cycle where cpu_rom_busy is high. A fetch that falls due while the CPU holds the ROM is issued in the next free cycle, so no sample is lost or repeated.
- R7: A count N (1 to 65535) produces exactly N DAC writes. A count of 0 sets done and leaves busy low in the cycle after the go write, and no DAC write follows.
- R8: In the cycle of the final dac_wr, busy is 0 and done is 1. After that, rom_req and dac_wr stay low and dac_data holds the last sample until the next go write.
- R9: A go write during playback restarts from the newly stored address and count. No sample from the abandoned transfer is written after the restart.
- R10: The ROM returns data in the cycle after rom_req, and the engine writes that byte to the DAC at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 3 | Register index |
| io_wdata | input | 8 | Register write data |
| cpu_rom_busy | input | 1 | CPU is using the ROM this cycle |
| rom_req | output | 1 | Sample fetch from ROM this cycle |
| rom_addr | output | 16 | Sample fetch address |
| rom_data | input | 8 | ROM read data, valid the cycle after rom_req |
| dac_wr | output | 1 | DAC write strobe, one cycle per sample |
| dac_data | output | 8 | DAC register contents |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Last transfer completed, cleared by go |

## Verification
All timing is counted from the clock edge that accepts the go write. When the ROM is free, the first DAC write is due D*TICK_DIV+2 edges later and each following write D*TICK_DIV edges after the one before. A fetch blocked by the CPU is due one or more cycles late, and only its value and count are checked, not its exact cycle. The bench keeps a free-running edge counter and stamps every dac_wr it samples at the falling clock edge. It compares those stamps and the sample values with the figures computed from the programmed divider and address. Status and hold checks are made at falling edges after the go write or after the final write.

// File: rtl/pcm_dma_pkg.sv
// Shared constants and register indices for the audio sample streaming DMA.
// Assumes byte-wide host writes and a 16-bit ROM address space.
package pcm_dma_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int LEN_W   = 16;
    localparam int DIV_W   = 8;
    localparam int IDX_W   = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_RATE   = 3'd0,
        REG_SRC_LO = 3'd1,
        REG_SRC_HI = 3'd2,
        REG_LEN_LO = 3'd3,
        REG_LEN_HI = 3'd4,
        REG_GO     = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/pcm_regs.sv
// Host register bank: holds the divider, start address and sample count,
// and decodes a write to the go index into a single-cycle start pulse.
// Assumes io_wr is a one-cycle strobe per byte written.
module pcm_regs
    import pcm_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IDX_W-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] src_addr,
    output logic [LEN_W-1:0]  len_cfg,
    output logic [DIV_W-1:0]  rate_div,
    output logic              go
);
    // Start pulse straight from the decoded strobe.
    always_comb begin
        go = io_wr && (io_addr == REG_GO);
    end

    // Store the byte written to its register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            len_cfg  <= '0;
            rate_div <= '0;
        end else if (io_wr) begin
            case (io_addr)
                REG_RATE:   rate_div        <= io_wdata;
                REG_SRC_LO: src_addr[7:0]   <= io_wdata;
                REG_SRC_HI: src_addr[15:8]  <= io_wdata;
                REG_LEN_LO: len_cfg[7:0]    <= io_wdata;
                REG_LEN_HI: len_cfg[15:8]   <= io_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcm_rate.sv
// Sample rate generator: a prescaler makes one tick per microsecond from
// TICK_DIV clocks, and a reload counter turns D ticks into one period tick.
// The divider is re-read at each period end, so a new value applies to the
// next period. A divider of 0 counts as 2**DIV_W.
module pcm_rate
    import pcm_dma_pkg::*;
#(
    parameter int TICK_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] rate_div,
    output logic             period_tick
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int PER_W = DIV_W + 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PER_W-1:0] per_cnt;
    logic [PER_W-1:0] reload;
    logic             us_tick;

    // Reload value with zero standing for the longest period.
    always_comb begin
        reload  = (rate_div == '0) ? PER_W'(1 << DIV_W) : {1'b0, rate_div};
        us_tick = run && (pre_cnt == PRE_W'(TICK_DIV - 1));
        period_tick = us_tick && (per_cnt == PER_W'(1));
    end

    // Advance the prescaler and period counter while playing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            per_cnt <= PER_W'(1 << DIV_W);
        end else if (restart) begin
            pre_cnt <= '0;
            per_cnt <= reload;
        end else if (run) begin
            if (us_tick) begin
                pre_cnt <= '0;
                per_cnt <= (per_cnt == PER_W'(1)) ? reload : per_cnt - PER_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/pcm_fetch.sv
// Fetch engine: counts sample periods owed, issues a ROM read only when the
// CPU leaves the ROM free, captures the byte one cycle later and writes it to
// the DAC register. Tracks address, remaining count, busy and done.
// Assumes ROM data is valid the cycle after rom_req.
module pcm_fetch
    import pcm_dma_pkg::*;
#(
    parameter int OWED_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [LEN_W-1:0]  len_cfg,
    input  logic              period_tick,
    input  logic              cpu_rom_busy,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [BYTE_W-1:0] dac_data,
    output logic              dac_wr,
    output logic              busy,
    output logic              done
);
    localparam logic [OWED_W-1:0] OWED_MAX = '1;

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  len_rem;
    logic [OWED_W-1:0] owed;
    logic              rd_valid;
    logic              last;
    logic              owe_inc;

    // Grant a fetch only in a cycle the CPU does not claim.
    always_comb begin
        rom_req  = busy && (owed != '0) && (len_rem != '0) && !cpu_rom_busy;
        rom_addr = cur_addr;
        owe_inc  = period_tick && busy && (owed != OWED_MAX);
    end

    // Sequence fetches, captures and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            len_rem  <= '0;
            owed     <= '0;
            rd_valid <= 1'b0;
            last     <= 1'b0;
            dac_data <= '0;
            dac_wr   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else if (go) begin
            cur_addr <= src_addr;
            len_rem  <= len_cfg;
            owed     <= '0;
            rd_valid <= 1'b0;
            last     <= 1'b0;
            dac_wr   <= 1'b0;
            busy     <= (len_cfg != '0);
            done     <= (len_cfg == '0);
        end else begin
            dac_wr <= 1'b0;
            owed   <= owed + OWED_W'(owe_inc) - OWED_W'(rom_req);
            rd_valid <= rom_req;
            if (rom_req) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                len_rem  <= len_rem - LEN_W'(1);
                last     <= (len_rem == LEN_W'(1));
            end
            if (rd_valid) begin
                dac_data <= rom_data;
                dac_wr   <= 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_stream_dma.sv
// Top of the audio sample streaming DMA. Joins the register bank, the rate
// generator and the fetch engine. The CPU is never stalled: fetches only use
// ROM cycles that cpu_rom_busy leaves free.
module pcm_stream_dma
    import pcm_dma_pkg::*;
#(
    parameter int TICK_DIV = 16,
    parameter int OWED_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IDX_W-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              cpu_rom_busy,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              dac_wr,
    output logic [BYTE_W-1:0] dac_data,
    output logic              busy,
    output logic              done
);
    logic [ADDR_W-1:0] src_addr;
    logic [LEN_W-1:0]  len_cfg;
    logic [DIV_W-1:0]  rate_div;
    logic              go;
    logic              period_tick;

    pcm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .src_addr(src_addr), .len_cfg(len_cfg),
        .rate_div(rate_div), .go(go)
    );

    pcm_rate #(.TICK_DIV(TICK_DIV)) u_rate (
        .clk(clk), .rst_n(rst_n), .restart(go), .run(busy),
        .rate_div(rate_div), .period_tick(period_tick)
    );

    pcm_fetch #(.OWED_W(OWED_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .src_addr(src_addr),
        .len_cfg(len_cfg), .period_tick(period_tick),
        .cpu_rom_busy(cpu_rom_busy), .rom_data(rom_data),
        .rom_req(rom_req), .rom_addr(rom_addr), .dac_data(dac_data),
        .dac_wr(dac_wr), .busy(busy), .done(done)
    );
endmodule

// File: rtl/pcm_dma_checker.sv
// Assertion checker for pcm_stream_dma, bound to every instance of the top.
module pcm_dma_checker
    import pcm_dma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [IDX_W-1:0]  io_addr,
    input logic              cpu_rom_busy,
    input logic              rom_req,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              dac_wr,
    input logic [BYTE_W-1:0] dac_data,
    input logic              busy,
    input logic              done
);
    logic start_wr;
    assign start_wr = io_wr && (io_addr == REG_GO);

    // R6: the ROM is never taken from the CPU
    a_r6_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> !cpu_rom_busy);

    // R10: every DAC write follows a ROM fetch two cycles earlier
    a_r10_write_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wr |-> $past(rom_req, 2));

    // R8: no fetch while idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rom_req);

    // R3: DAC register moves only with its strobe
    a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_wr |-> $stable(dac_data));

    // R8: done and busy are exclusive
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: address advances by one per fetch
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && !start_wr) |=> (rom_addr == $past(rom_addr) + 16'd1));
endmodule

bind pcm_stream_dma pcm_dma_checker u_chk (.*);

// File: tb/tb_pcm_stream_dma.sv
module tb_pcm_stream_dma;
    localparam int T = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [2:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       cpu_rom_busy = 1'b0;
    logic       rom_req;
    logic [15:0] rom_addr;
    logic [7:0] rom_data = '0;
    logic       dac_wr;
    logic [7:0] dac_data;
    logic       busy;
    logic       done;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int cpu_mode = 0;
    int viol = 0;
    int ev_n = 0;
    logic [7:0] ev_val [256];
    int ev_t [256];

    pcm_stream_dma #(.TICK_DIV(T)) dut (.*);

    always #10 clk = ~clk;

    function automatic logic [7:0] romf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rom_req) rom_data <= romf(rom_addr);
        cpu_rom_busy <= (cpu_mode == 1) ? ~cpu_rom_busy : (cpu_mode == 2);
    end

    always @(negedge clk) begin
        if (rst_n && dac_wr && ev_n < 256) begin
            ev_val[ev_n] <= dac_data;
            ev_t[ev_n]   <= cyc;
            ev_n <= ev_n + 1;
        end
        if (rst_n && rom_req && cpu_rom_busy) viol <= viol + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // program and start; returns edge count of the go edge (R2)
    task automatic start(input logic [15:0] src, input logic [15:0] len,
                         input logic [7:0] dv, output int s);
        wr(3'd0, dv);
        wr(3'd1, src[7:0]);
        wr(3'd2, src[15:8]);
        wr(3'd3, len[7:0]);
        wr(3'd4, len[15:8]);
        wr(3'd5, 8'h00);
        s = cyc;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // src, len, div, cpu mode
    localparam logic [47:0] VEC [4] = '{
        {16'h1000, 16'd4, 8'd4,  8'd0},
        {16'hFFFE, 16'd3, 8'd5,  8'd0},
        {16'h2345, 16'd5, 8'd3,  8'd1},
        {16'h0A0A, 16'd2, 8'd20, 8'd0}
    };

    initial begin
        int s, b, d, n;
        logic [15:0] src;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(rom_req == 0, "R1 rom_req", rom_req, 0);
        chk(dac_wr == 0, "R1 dac_wr", dac_wr, 0);
        chk(dac_data == 0, "R1 dac_data", dac_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table: R2 R3 R4 R6 R7 R8 R10
        for (int v = 0; v < 4; v++) begin
            src = VEC[v][47:32];
            n = int'(VEC[v][31:16]);
            d = int'(VEC[v][15:8]);
            cpu_mode = int'(VEC[v][7:0]);
            b = ev_n;
            start(src, VEC[v][31:16], VEC[v][15:8], s);
            wait_done();
            cpu_mode = 0;
            chk(ev_n - b == n, "R7 sample count", ev_n - b, n);
            for (int k = 0; k < n && k < ev_n - b; k++) begin
                chk(ev_val[b+k] == romf(src + 16'(k)), "R3/R10 sample value",
                    ev_val[b+k], romf(src + 16'(k)));
                if (cpu_mode == 0 && VEC[v][7:0] == 0) begin
                    if (k == 0)
                        chk(ev_t[b] == s + d*T + 2, "R4 first write", ev_t[b] - s, d*T + 2);
                    else
                        chk(ev_t[b+k] - ev_t[b+k-1] == d*T, "R4 period",
                            ev_t[b+k] - ev_t[b+k-1], d*T);
                end else if (k == 0) begin
                    chk(ev_t[b] >= s + d*T + 2 && ev_t[b] <= s + d*T + 3,
                        "R6 first write delay", ev_t[b] - s, d*T + 2);
                end
            end
            chk(busy == 0 && done == 1, "R8 status", {busy, done}, 1);
        end

        // R8 hold after completion
        b = ev_n;
        repeat (40) @(negedge clk);
        chk(ev_n == b, "R8 no further writes", ev_n - b, 0);
        chk(dac_data == romf(16'h0A0B), "R8 last sample held", dac_data, romf(16'h0A0B));

        // R4 divider 0 means 256
        b = ev_n;
        start(16'h0100, 16'd2, 8'd0, s);
        wait_done();
        chk(ev_n - b == 2, "R4 div0 count", ev_n - b, 2);
        chk(ev_t[b+1] - ev_t[b] == 256*T, "R4 div0 period", ev_t[b+1] - ev_t[b], 256*T);

        // R5 rate change mid playback
        b = ev_n;
        start(16'h0200, 16'd3, 8'd4, s);
        while (ev_n == b) @(negedge clk);
        wr(3'd0, 8'd8);
        wait_done();
        chk(ev_n - b == 3, "R5 count", ev_n - b, 3);
        chk(ev_t[b+1] - ev_t[b] == 4*T, "R5 current period kept", ev_t[b+1] - ev_t[b], 4*T);
        chk(ev_t[b+2] - ev_t[b+1] == 8*T, "R5 new period", ev_t[b+2] - ev_t[b+1], 8*T);

        // R7 zero length
        b = ev_n;
        start(16'h0300, 16'd0, 8'd4, s);
        chk(done == 1 && busy == 0, "R7 zero length status", {busy, done}, 1);
        repeat (30) @(negedge clk);
        chk(ev_n == b, "R7 zero length no write", ev_n - b, 0);

        // R6 CPU holds the ROM past the period end
        b = ev_n;
        cpu_mode = 2;
        start(16'h0400, 16'd1, 8'd4, s);
        repeat (4*T + 10) @(negedge clk);
        chk(ev_n == b && busy == 1, "R6 fetch held", ev_n - b, 0);
        cpu_mode = 0;
        wait_done();
        chk(ev_n - b == 1, "R6 no drop no repeat", ev_n - b, 1);
        chk(ev_val[b] == romf(16'h0400), "R6 held sample value", ev_val[b], romf(16'h0400));

        // R9 restart while busy
        b = ev_n;
        start(16'h3000, 16'd5, 8'd8, s);
        while (ev_n < b + 2) @(negedge clk);
        start(16'h5000, 16'd2, 8'd8, s);
        wait_done();
        n = 0;
        for (int k = b; k < ev_n; k++) if (ev_t[k] > s) n++;
        chk(n == 2, "R9 samples after restart", n, 2);
        chk(ev_val[ev_n-2] == romf(16'h5000), "R9 first new sample", ev_val[ev_n-2], romf(16'h5000));
        chk(ev_val[ev_n-1] == romf(16'h5001), "R9 second new sample", ev_val[ev_n-1], romf(16'h5001));

        chk(viol == 0, "R6 rom_req during cpu use", viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule